// File: doc/BRIEF.md
# Bus-Idle Standby Controller

This block decides when a host bus has gone quiet and raises a standby request for the rest of the chip. It watches the address latch enable (ALE) strobe of the host bus. When the strobe stops toggling and stays at a chosen level long enough, the block asserts standby. Software sets the chosen level, the enable and the source of the counting clock through two small configuration registers. The block uses either the main clock or an alternate input pin as the tick source for its idle counter.

The same two registers also drive several static power-control outputs:

- a current-saving enable for the on-chip memories;
- a power-down enable for the programmable logic array;
- three clock-disconnect gates, for the array, the macrocell registers and the timer;
- a sleep-mode enable.

The block only produces these control signals. The logic they gate lives elsewhere. Everything runs in the main clock domain. The alternate input is synchronised and turned into single-cycle ticks.

Top module: `bus_idle_pwrdn`

## Requirements
- R1: After a synchronous reset, both configuration registers read 0, every power-control output is 0 and standby is low.
- R2: Configuration register 0 (address 0) stores and reads back all 8 bits. Configuration register 1 (address 1) stores only bits 1:0. Its bits 7:2 read as zero whatever was written. Read data appears one clock after the address is presented.
- R3: In register 0, bit 3 drives the memory current-saving output, bit 4 the array power-down enable, bit 5 the array clock gate, bit 6 the macrocell clock gate and bit 7 the timer clock gate. Register 1 bit 1 drives the sleep enable. Each output follows its bit one clock after the write.
- R4: Counting is armed when register 0 bits 0 and 2 are both 1. Register 0 bit 1 gives the idle level of the strobe: 0 means low, 1 means high. While armed with the strobe steady at that level, standby rises after 15 ticks and not earlier.
- R5: When register 0 bit 2 or bit 0 is 0, the counter does not advance and standby stays low.
- R6: A strobe that keeps toggling never produces standby. Any single transition of the strobe clears the count and removes standby within 3 clocks.
- R7: While the strobe is steady at the level opposite to the idle level, standby stays low.
- R8: Register 1 bit 0 selects the tick source. When it is 1, every main clock is a tick. When it is 0, each rising edge of the alternate input is one tick, so a stuck alternate input never produces standby.
- R9: Once asserted, standby holds for as long as the strobe stays idle and counting stays armed. The counter saturates and does not wrap.
- R10: Clearing register 0 bit 2 while standby is high removes standby within 3 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 or 1) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for reg_addr |
| ale_in | input | 1 | Bus address latch enable strobe |
| alt_clk_in | input | 1 | Alternate tick source, asynchronous |
| standby_o | output | 1 | Standby request |
| mem_saver_o | output | 1 | Memory current-saving enable |
| array_pd_en_o | output | 1 | Logic array power-down enable (turbo off) |
| array_clk_gate_o | output | 1 | Disconnect main clock from the array |
| mcell_clk_gate_o | output | 1 | Disconnect main clock from macrocell registers |
| timer_clk_gate_o | output | 1 | Disconnect main clock from the timer |
| sleep_en_o | output | 1 | Sleep mode enable |

## Verification
The bench probes the edges of the 15-tick window. It checks that standby is still low a few ticks short of the limit, which catches an off-by-one that fires early. It also checks that standby is high once the limit has passed and stays high long after, which catches a counter that wraps and lets standby drop.

A single strobe pulse during standby must clear the request. A design that checked only the strobe level, and ignored transitions, would keep standby high through short pulses. Both idle polarities, the opposite level, each disarm bit and a stuck alternate tick input are also exercised. A design that ignores the polarity bit or the tick select would raise standby in one of those cases.

Writing all ones to register 1 exposes reserved bits that were stored rather than forced to zero.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int REG_W = 8;

  // register 0 bit positions
  localparam int B0_RUN      = 0;
  localparam int B0_POL      = 1;
  localparam int B0_EN       = 2;
  localparam int B0_MEMSAVE  = 3;
  localparam int B0_ARRAY_PD = 4;
  localparam int B0_ARR_GATE = 5;
  localparam int B0_MC_GATE  = 6;
  localparam int B0_TMR_GATE = 7;

  // register 1 bit positions
  localparam int B1_TICK_MAIN = 0;
  localparam int B1_SLEEP     = 1;
  localparam int R1_W         = 2;

  typedef struct packed {
    logic tick_main;
    logic sleep;
    logic tmr_gate;
    logic mc_gate;
    logic arr_gate;
    logic array_pd;
    logic mem_save;
    logic enable;
    logic polarity;
    logic run;
  } pwr_cfg_t;
endpackage

// File: rtl/pdc_regs.sv
module pdc_regs
  import pdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output pwr_cfg_t         cfg
);
  logic [REG_W-1:0] mode0_q;
  logic [R1_W-1:0]  mode1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode0_q <= '0;
      mode1_q <= '0;
    end else if (wr_en) begin
      if (addr) mode1_q <= wdata[R1_W-1:0];
      else      mode0_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= addr ? {{(REG_W-R1_W){1'b0}}, mode1_q} : mode0_q;
  end

  always_comb begin
    cfg.run       = mode0_q[B0_RUN];
    cfg.polarity  = mode0_q[B0_POL];
    cfg.enable    = mode0_q[B0_EN];
    cfg.mem_save  = mode0_q[B0_MEMSAVE];
    cfg.array_pd  = mode0_q[B0_ARRAY_PD];
    cfg.arr_gate  = mode0_q[B0_ARR_GATE];
    cfg.mc_gate   = mode0_q[B0_MC_GATE];
    cfg.tmr_gate  = mode0_q[B0_TMR_GATE];
    cfg.tick_main = mode1_q[B1_TICK_MAIN];
    cfg.sleep     = mode1_q[B1_SLEEP];
  end

  // R2: reserved bits of register 1 always read back as zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(addr) |-> (rdata[REG_W-1:R1_W] == '0));
endmodule

// File: rtl/pdc_tick_gen.sv
module pdc_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic alt_in,
  input  logic sel_main,
  output logic tick
);
  localparam int LAST = SYNC_STAGES - 1;

  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      logic q;
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= 1'b0;
          else     q <= alt_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= 1'b0;
          else     q <= g_sync[i-1].q;
        end
      end
    end
  endgenerate

  logic alt_sync;
  logic alt_prev_q;
  assign alt_sync = g_sync[LAST].q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_prev_q <= 1'b0;
      tick       <= 1'b0;
    end else begin
      alt_prev_q <= alt_sync;
      tick       <= sel_main ? 1'b1 : (alt_sync & ~alt_prev_q);
    end
  end

  // R8: in alternate mode a tick is a single-cycle pulse
  p_tick_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (!sel_main && tick) |=> (sel_main || $past(sel_main) || !tick));
endmodule

// File: rtl/pdc_idle_counter.sv
module pdc_idle_counter #(
  parameter int IDLE_TICKS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic polarity,
  input  logic ale_in,
  input  logic tick,
  output logic standby
);
  localparam int CNT_W = $clog2(IDLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(IDLE_TICKS);

  logic             ale_q, ale_qq;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             edge_seen, at_idle_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q  <= 1'b0;
      ale_qq <= 1'b0;
    end else begin
      ale_q  <= ale_in;
      ale_qq <= ale_q;
    end
  end

  assign edge_seen   = ale_q ^ ale_qq;
  assign at_idle_lvl = (ale_q == polarity);

  always_comb begin
    cnt_nxt = cnt_q;
    if (!armed || edge_seen || !at_idle_lvl) cnt_nxt = '0;
    else if (tick && (cnt_q != LIMIT))      cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      standby <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      standby <= (cnt_nxt == LIMIT);
    end
  end

  // R5: disarmed counter is cleared
  p_disarm_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (cnt_q == '0 && !standby));
  // R6: strobe transition clears the count
  p_edge_clear_r6: assert property (@(posedge clk) disable iff (rst)
    edge_seen |=> (cnt_q == '0));
  // R4: the count advances by at most one per cycle
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));
  // R4: standby only rises from the last step of the count
  p_rise_at_limit_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(standby) |-> ($past(cnt_q) == LIMIT - 1'b1));
  // R9: a saturated count holds while idle conditions persist
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (standby && armed && !edge_seen && at_idle_lvl) |=> standby);
endmodule

// File: rtl/bus_idle_pwrdn.sv
module bus_idle_pwrdn
  import pdc_pkg::*;
#(
  parameter int IDLE_TICKS  = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr_en,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ale_in,
  input  logic       alt_clk_in,
  output logic       standby_o,
  output logic       mem_saver_o,
  output logic       array_pd_en_o,
  output logic       array_clk_gate_o,
  output logic       mcell_clk_gate_o,
  output logic       timer_clk_gate_o,
  output logic       sleep_en_o
);
  pwr_cfg_t cfg;
  logic     tick;
  logic     armed;

  pdc_regs u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (reg_wr_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg   (cfg)
  );

  pdc_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .alt_in   (alt_clk_in),
    .sel_main (cfg.tick_main),
    .tick     (tick)
  );

  assign armed = cfg.run & cfg.enable;

  pdc_idle_counter #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .armed    (armed),
    .polarity (cfg.polarity),
    .ale_in   (ale_in),
    .tick     (tick),
    .standby  (standby_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_saver_o      <= 1'b0;
      array_pd_en_o    <= 1'b0;
      array_clk_gate_o <= 1'b0;
      mcell_clk_gate_o <= 1'b0;
      timer_clk_gate_o <= 1'b0;
      sleep_en_o       <= 1'b0;
    end else begin
      mem_saver_o      <= cfg.mem_save;
      array_pd_en_o    <= cfg.array_pd;
      array_clk_gate_o <= cfg.arr_gate;
      mcell_clk_gate_o <= cfg.mc_gate;
      timer_clk_gate_o <= cfg.tmr_gate;
      sleep_en_o       <= cfg.sleep;
    end
  end

  // R3: outputs track the configuration one cycle later
  p_outs_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_saver_o == $past(cfg.mem_save)) && (sleep_en_o == $past(cfg.sleep)));
  // R10: standby cannot persist once counting is disarmed
  p_disarm_drop_r10: assert property (@(posedge clk) disable iff (rst)
    !armed |=> !standby_o);
endmodule

// File: tb/bus_idle_pwrdn_tb.sv
module bus_idle_pwrdn_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ale_in = 1'b0;
  logic       alt_clk_in = 1'b0;
  logic       standby_o, mem_saver_o, array_pd_en_o, array_clk_gate_o;
  logic       mcell_clk_gate_o, timer_clk_gate_o, sleep_en_o;

  bus_idle_pwrdn u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale_in(ale_in),
    .alt_clk_in(alt_clk_in), .standby_o(standby_o), .mem_saver_o(mem_saver_o),
    .array_pd_en_o(array_pd_en_o), .array_clk_gate_o(array_clk_gate_o),
    .mcell_clk_gate_o(mcell_clk_gate_o), .timer_clk_gate_o(timer_clk_gate_o),
    .sleep_en_o(sleep_en_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string      req;
    int         sel;   // 0 read data, 1 standby, 2 static outputs
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [7:0] outs_vec();
    return {2'b00, sleep_en_o, timer_clk_gate_o, mcell_clk_gate_o,
            array_clk_gate_o, array_pd_en_o, mem_saver_o};
  endfunction

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.sel)
        0:       act = reg_rdata;
        1:       act = {7'b0, standby_o};
        default: act = outs_vec();
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    cyc(1);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic a, logic [7:0] exp);
    reg_addr = a;
    cyc(1);
    push(req, 0, exp);
    cyc(1);
  endtask

  task automatic chk_sb(string req, logic exp);
    push(req, 1, {7'b0, exp});
    cyc(1);
  endtask

  task automatic toggle_alt(int n);
    for (int k = 0; k < n; k++) begin
      cyc(4); alt_clk_in = ~alt_clk_in;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1 reset state
    rd("R1 reg0", 1'b0, 8'h00);
    rd("R1 reg1", 1'b1, 8'h00);
    push("R1 outs", 2, 8'h00); cyc(1);
    chk_sb("R1 standby", 1'b0);

    // R2 readback and reserved bits
    wr(1'b0, 8'hA6);
    rd("R2 reg0", 1'b0, 8'hA6);
    wr(1'b1, 8'hFF);
    rd("R2 reg1 reserved", 1'b1, 8'h03);

    // R3 static outputs: reg0 bits 3..7, reg1 bit1
    wr(1'b0, 8'hF8);
    cyc(2);
    push("R3 outs all", 2, 8'h3F); cyc(1);
    wr(1'b0, 8'h50); wr(1'b1, 8'h01);
    cyc(2);
    push("R3 outs mix", 2, 8'h0A); cyc(1);

    // R4 main tick, idle level low
    ale_in = 1'b0;
    wr(1'b0, 8'h05);
    cyc(11);
    chk_sb("R4 early", 1'b0);
    cyc(8);
    chk_sb("R4 reached", 1'b1);
    // R9 hold
    cyc(50);
    chk_sb("R9 hold", 1'b1);
    // R6 single pulse drops standby
    ale_in = 1'b1; cyc(1); ale_in = 1'b0;
    cyc(2);
    chk_sb("R6 pulse clears", 1'b0);
    // R6 toggling strobe
    for (int k = 0; k < 15; k++) begin ale_in = ~ale_in; cyc(4); end
    ale_in = 1'b0;
    chk_sb("R6 toggling", 1'b0);
    cyc(25);
    chk_sb("R4 after toggling", 1'b1);
    // R10 disable drops standby
    wr(1'b0, 8'h01);
    cyc(2);
    chk_sb("R10 disarm", 1'b0);
    // R5 run bit clear
    wr(1'b0, 8'h04);
    cyc(40);
    chk_sb("R5 run clear", 1'b0);

    // R7 opposite level, R4 high polarity
    wr(1'b0, 8'h07);
    cyc(40);
    chk_sb("R7 opposite level", 1'b0);
    ale_in = 1'b1;
    cyc(12);
    chk_sb("R4 high pol early", 1'b0);
    cyc(10);
    chk_sb("R4 high pol reached", 1'b1);

    // R8 alternate tick source
    ale_in = 1'b0;
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h05);
    cyc(100);
    chk_sb("R8 stuck alt", 1'b0);
    fork toggle_alt(60); join_none
    cyc(60);
    chk_sb("R8 alt early", 1'b0);
    cyc(90);
    chk_sb("R8 alt reached", 1'b1);
    cyc(100);

    cyc(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule